// File: doc/BRIEF.md
# Serial Gain Word Receiver

This block is the digital control front end of a programmable-gain amplifier. A host writes a seven-bit control word over a three-wire bus made up of an active-low select, a serial clock and a data line. The block collects the bits in a shift register and copies them into a holding register when the select line returns high. The holding register drives a six-bit gain code, with one step per dB from about -25 dB at code 0 to about +31 dB at code 56, and a software sleep flag.

A fast system clock samples all three bus lines through two-flop synchronizers, and all edges are found in that clock domain. The bus therefore has to be slow compared with the system clock. The block also merges the stored sleep flag with the hardware shutdown and transmit-enable pins into one signal-path enable. A shutdown erases the stored word, so the host must write it again afterwards. Transmit-disable only turns off the signal path and leaves the bus and the stored word as they are.

Top module: `gain_word_rx`

## Requirements
- R1: The word is sent least-significant bit first. The seventh bit received (bit 6) is the sleep command, and bits 5..0 form the gain code, with bit 5 as its MSB.
- R2: While select is low, each rising serial clock edge captures one data bit. The outputs take the new word on the third rising system clock edge after the select rise is first sampled, and not before.
- R3: While a transfer is in progress, the gain code, sleep and gain_valid outputs keep the previously stored word.
- R4: Serial clock edges while select is high do not change the shift register or the outputs.
- R5: A stored gain field of 57..63 appears as 56 on gain_code. Values 0..56 appear unchanged.
- R6: The sleep output equals stored bit 6. While sleep is 1, path_enable is 0.
- R7: While txen is low, path_enable is 0, and words are still received and stored.
- R8: While shdn_n is low, the stored word and gain_valid are cleared on every system clock edge and path_enable is 0. After release they stay cleared until a new word is stored.
- R9: While rst_n is low, all outputs are 0.
- R10: If a transfer has more than seven serial clocks, the last seven bits are stored. A select rise after fewer than seven bits since the select fall still copies the shift register, but it does not set gain_valid.
- R11: path_enable is 1 only when shdn_n, txen and gain_valid are all 1 and sleep is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| shdn_n | input | 1 | Active-low hardware shutdown; clears the stored word |
| txen | input | 1 | Transmit enable for the signal path |
| bus_sel_n | input | 1 | Serial bus select, active low |
| bus_sclk | input | 1 | Serial bus clock |
| bus_sdat | input | 1 | Serial bus data |
| gain_code | output | 6 | Clamped gain step, 0..56 |
| sleep | output | 1 | Stored software sleep command |
| gain_valid | output | 1 | A complete word has been stored since reset or shutdown |
| path_enable | output | 1 | Signal path on |

## Verification
A shift register with a wrong bit order or a missed strobe shows up as a wrong gain_code three system clocks after the select rise that ends the transfer. A holding register that follows the shift register during a transfer shows up as gain_code moving while select is still low. A count that saturates badly shows up as gain_valid staying at 0 after a full word, or rising after a short one. A reference model that runs in step with the design is compared with every output on every system clock, so any such error is reported within the cycle in which it first reaches a port.

// File: rtl/gwr_pkg.sv
package gwr_pkg;

    // Edge events found on the synchronized bus lines in one system clock
    typedef struct packed {
        logic sel_rise;
        logic sel_fall;
        logic bit_strobe;
    } bus_evt_t;

endpackage

// File: rtl/gwr_sync.sv
module gwr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/gwr_shift.sv
module gwr_shift
    import gwr_pkg::*;
#(
    parameter int WORD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_n,
    input  logic              sel_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              load,
    output logic              full,
    output logic [WORD_W-1:0] shreg
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic              sel_prev;
        logic              sclk_prev;
        logic [WORD_W-1:0] bits;
        logic [CNT_W-1:0]  cnt;
    } shift_t;

    shift_t   st_d, st_q;
    bus_evt_t evt;

    always_comb begin
        evt.sel_rise   = sel_s & ~st_q.sel_prev;
        evt.sel_fall   = ~sel_s & st_q.sel_prev;
        evt.bit_strobe = ~sel_s & sclk_s & ~st_q.sclk_prev;

        st_d           = st_q;
        st_d.sel_prev  = sel_s;
        st_d.sclk_prev = sclk_s;
        if (!shdn_n) begin
            st_d.bits = '0;
            st_d.cnt  = '0;
        end else if (evt.sel_fall) begin
            st_d.cnt = '0;
        end else if (evt.bit_strobe) begin
            // new bit enters at the top so the first bit ends at bit 0
            st_d.bits = {sdat_s, st_q.bits[WORD_W-1:1]};
            if (st_q.cnt != CNT_FULL) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_prev  <= 1'b1;
            st_q.sclk_prev <= 1'b0;
            st_q.bits      <= '0;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load  = evt.sel_rise;
    assign full  = (st_q.cnt == CNT_FULL);
    assign shreg = st_q.bits;

    // R4: nothing is shifted while the synchronized select is high
    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && shdn_n) |=> $stable(shreg));

endmodule

// File: rtl/gwr_hold.sv
module gwr_hold #(
    parameter int WORD_W   = 7,
    parameter int GAIN_MAX = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_n,
    input  logic              txen,
    input  logic              load,
    input  logic              full,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-2:0] gain_code,
    output logic              sleep,
    output logic              gain_valid,
    output logic              path_enable
);

    localparam int GAIN_W = WORD_W - 1;
    localparam logic [GAIN_W-1:0] GAIN_TOP = GAIN_W'(GAIN_MAX);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (!shdn_n) begin
            hd_d = '0;
        end else if (load) begin
            hd_d.word = word_in;
            if (full) begin
                hd_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    always_comb begin
        if (hd_q.word[GAIN_W-1:0] > GAIN_TOP) begin
            gain_code = GAIN_TOP;
        end else begin
            gain_code = hd_q.word[GAIN_W-1:0];
        end
    end

    assign sleep       = hd_q.word[WORD_W-1];
    assign gain_valid  = hd_q.valid;
    assign path_enable = shdn_n & txen & ~sleep & hd_q.valid;

    // R3: the stored word moves only on a load or a shutdown
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && !load) |=> $stable(hd_q.word));

    // R8: shutdown wipes the stored word and the valid flag
    assert_shdn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (hd_q.word == '0 && !hd_q.valid));

    // R10: valid rises only after a load from a full shift register
    assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hd_q.valid) |-> $past(load && full));

    // R5: the gain output never exceeds the top step
    assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code <= GAIN_TOP);

endmodule

// File: rtl/gain_word_rx.sv
module gain_word_rx #(
    parameter int WORD_W      = 7,
    parameter int GAIN_MAX    = 56,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shdn_n,
    input  logic              txen,
    input  logic              bus_sel_n,
    input  logic              bus_sclk,
    input  logic              bus_sdat,
    output logic [WORD_W-2:0] gain_code,
    output logic              sleep,
    output logic              gain_valid,
    output logic              path_enable
);

    localparam int BUS_W = 3;

    logic [BUS_W-1:0]  bus_s;
    logic              load, full;
    logic [WORD_W-1:0] shreg;

    // bit 0 select (idles high), bit 1 serial clock, bit 2 data
    gwr_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bus_sdat, bus_sclk, bus_sel_n}),
        .dout  (bus_s)
    );

    gwr_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .shdn_n (shdn_n),
        .sel_s  (bus_s[0]),
        .sclk_s (bus_s[1]),
        .sdat_s (bus_s[2]),
        .load   (load),
        .full   (full),
        .shreg  (shreg)
    );

    gwr_hold #(
        .WORD_W   (WORD_W),
        .GAIN_MAX (GAIN_MAX)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .shdn_n      (shdn_n),
        .txen        (txen),
        .load        (load),
        .full        (full),
        .word_in     (shreg),
        .gain_code   (gain_code),
        .sleep       (sleep),
        .gain_valid  (gain_valid),
        .path_enable (path_enable)
    );

endmodule

// File: tb/gain_word_rx_test.sv
module gain_word_rx_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shdn_n = 1'b1;
    logic       txen = 1'b1;
    logic       bus_sel_n = 1'b1;
    logic       bus_sclk = 1'b0;
    logic       bus_sdat = 1'b0;
    logic [5:0] gain_code;
    logic       sleep, gain_valid, path_enable;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_in[$];
    int m_sh = 0, m_cnt = 0, m_lat = 0, m_val = 0;
    int m_selp = 1, m_sclkp = 0;

    gain_word_rx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .shdn_n      (shdn_n),
        .txen        (txen),
        .bus_sel_n   (bus_sel_n),
        .bus_sclk    (bus_sclk),
        .bus_sdat    (bus_sdat),
        .gain_code   (gain_code),
        .sleep       (sleep),
        .gain_valid  (gain_valid),
        .path_enable (path_enable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_gain();
        int g = m_lat % 64;
        return (g > 56) ? 56 : g;
    endfunction

    function automatic int exp_pe();
        return (shdn_n && txen && ((m_lat / 64) % 2 == 0) && m_val != 0) ? 1 : 0;
    endfunction

    // model update on every edge, compare a little later
    always @(posedge clk) begin
        int sample, sel, sc, dt;
        sample = (bus_sdat ? 4 : 0) + (bus_sclk ? 2 : 0) + (bus_sel_n ? 1 : 0);
        if (!rst_n) begin
            m_in = {1, 1};
            m_sh = 0; m_cnt = 0; m_lat = 0; m_val = 0;
            m_selp = 1; m_sclkp = 0;
        end else begin
            int seen;
            seen = m_in.pop_front();
            sel = seen % 2;
            sc  = (seen / 2) % 2;
            dt  = (seen / 4) % 2;
            if (!shdn_n) begin
                m_sh = 0; m_cnt = 0; m_lat = 0; m_val = 0;
            end else begin
                if (sel == 1 && m_selp == 0) begin
                    m_lat = m_sh;
                    if (m_cnt >= 7) m_val = 1;
                end
                if (sel == 0 && m_selp == 1) begin
                    m_cnt = 0;
                end else if (sel == 0 && sc == 1 && m_sclkp == 0) begin
                    m_sh = (m_sh / 2) + dt * 64;
                    if (m_cnt < 7) m_cnt++;
                end
            end
            m_selp = sel;
            m_sclkp = sc;
            m_in.push_back(sample);
        end
        #2;
        checks++;
        if (gain_code != 6'(exp_gain()) || sleep != 1'((m_lat / 64) % 2) ||
            gain_valid != 1'(m_val) || path_enable != 1'(exp_pe())) begin
            errors++;
            $display("FAIL R2 R11 per-cycle model: got g=%0d s=%0b v=%0b pe=%0b exp g=%0d s=%0d v=%0d pe=%0d",
                     gain_code, sleep, gain_valid, path_enable,
                     exp_gain(), (m_lat / 64) % 2, m_val, exp_pe());
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(string tag, int g, int s, int v, int p);
        checks++;
        if (gain_code != 6'(g) || sleep != 1'(s) || gain_valid != 1'(v) || path_enable != 1'(p)) begin
            errors++;
            $display("FAIL %s: got g=%0d s=%0b v=%0b pe=%0b exp g=%0d s=%0d v=%0d pe=%0d",
                     tag, gain_code, sleep, gain_valid, path_enable, g, s, v, p);
        end
    endtask

    task automatic shift_bits(int n, int bits);
        for (int i = 0; i < n; i++) begin
            bus_sdat = ((bits >> i) & 1) != 0;
            wait_clk(3);
            bus_sclk = 1'b1;
            wait_clk(3);
            bus_sclk = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic open_bus();
        bus_sel_n = 1'b0;
        wait_clk(3);
    endtask

    task automatic close_bus();
        wait_clk(3);
        bus_sel_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic send(int n, int bits);
        open_bus();
        shift_bits(n, bits);
        close_bus();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(4);
        check_out("R9 reset state", 0, 0, 0, 0);
        rst_n = 1'b1;
        wait_clk(3);
        check_out("R9 after reset", 0, 0, 0, 0);

        // R1: LSB first, gain 37
        send(7, 37);
        check_out("R1 word 37", 37, 0, 1, 1);

        // R3: mid-transfer outputs hold
        open_bus();
        shift_bits(4, 5);
        check_out("R3 hold during transfer", 37, 0, 1, 1);
        shift_bits(3, 5 >> 4);
        wait_clk(3);
        bus_sel_n = 1'b1;
        // R2: latency of the select rise
        wait_clk(2);
        check_out("R2 not yet updated", 37, 0, 1, 1);
        wait_clk(1);
        check_out("R2 updated on third edge", 5, 0, 1, 1);
        wait_clk(4);

        // R4: clocks with select high are ignored
        bus_sdat = 1'b1;
        for (int k = 0; k < 5; k++) begin
            bus_sclk = 1'b1; wait_clk(3);
            bus_sclk = 1'b0; wait_clk(3);
        end
        check_out("R4 idle clocks ignored", 5, 0, 1, 1);

        // R5: clamp and boundaries
        send(7, 63);
        check_out("R5 clamp 63", 56, 0, 1, 1);
        send(7, 57);
        check_out("R5 clamp 57", 56, 0, 1, 1);
        send(7, 56);
        check_out("R5 top 56", 56, 0, 1, 1);
        send(7, 0);
        check_out("R5 bottom 0", 0, 0, 1, 1);

        // R6: sleep bit
        send(7, 64 + 10);
        check_out("R6 sleep set", 10, 1, 1, 0);
        send(7, 10);
        check_out("R6 sleep cleared", 10, 0, 1, 1);

        // R7: transmit disable
        txen = 1'b0;
        wait_clk(1);
        check_out("R7 txen low", 10, 0, 1, 0);
        send(7, 20);
        check_out("R7 word stored with txen low", 20, 0, 1, 0);
        txen = 1'b1;
        wait_clk(1);
        check_out("R11 path on", 20, 0, 1, 1);

        // R8: shutdown
        shdn_n = 1'b0;
        wait_clk(3);
        check_out("R8 shutdown clears", 0, 0, 0, 0);
        shdn_n = 1'b1;
        wait_clk(3);
        check_out("R8 stays cleared after release", 0, 0, 0, 0);
        send(7, 33);
        check_out("R8 rewrite after shutdown", 33, 0, 1, 1);

        // R10: nine clocks, last seven kept
        send(9, 3 + (42 << 2));
        check_out("R10 overlong transfer", 42, 0, 1, 1);

        // R10: short transfer after shutdown does not set valid
        shdn_n = 1'b0;
        wait_clk(2);
        shdn_n = 1'b1;
        wait_clk(2);
        send(3, 7);
        check_out("R10 short transfer", 48, 1, 0, 0);
        send(7, 12);
        check_out("R10 full transfer after short", 12, 0, 1, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule